// File: doc/BRIEF.md
# Masked Vector Element Engine

The engine holds a small set of vector registers and a single mask register that has one bit per element position. A command selects an operation, a destination, two sources, a vector length and an issue policy. Compare commands write mask bits from two source vectors. A complement command inverts the mask. Arithmetic commands (add, move) write a destination element only where the corresponding mask bit is set. Positions at or beyond the vector length are never touched by arithmetic.

There are two issue policies, and both produce the same register contents. In gated issue, every element below the vector length takes one slot, and the mask only drives the write enable of the single write port. In dense issue, arithmetic commands walk only the positions whose mask bit is set, so the run time follows the mask population. A done pulse and an executed-element count let software compare the two policies in cycles. A per-element load port and a registered read port fill and inspect the registers while the engine is idle. One common use is an element-wise select: compare, masked move of A, complement, masked move of B.

Top module: `masked_vec_unit`

## Requirements
- R1: After reset, busy, done and exec_count are 0 and mask_out is all zeros.
- R2: Op code 0 sets mask bit i to (signed a[i] >= signed b[i]), and op code 1 sets it to (a[i] == 0), for every i below vlen. Both clear every mask bit at or above vlen.
- R3: Op code 2 inverts mask bits below vlen and clears mask bits at or above vlen.
- R4: Op code 3 (add, wrapping modulo 2^EW) and op code 4 (move a) write dst element i only when i < vlen and mask bit i is 1. Every other dst element keeps its value, and the mask is unchanged.
- R5: With dense = 0, every command occupies max(1, vlen) slots and reports exec_count = vlen.
- R6: With dense = 1, add and move occupy max(1, P) slots and report exec_count = P, where P is the number of set mask bits below vlen.
- R7: With dense = 1 and no set mask bit below vlen, add or move finishes after one slot, reports exec_count = 0 and writes nothing.
- R8: Mask commands (codes 0 to 2) occupy max(1, vlen) slots whatever the value of dense.
- R9: A command accepted at clock edge E raises done for exactly one cycle at edge E + slots. Busy is low while done is high.
- R10: While idle, ld_en writes ld_data into element ld_idx of register ld_reg at the clock edge. rd_data shows element rd_idx of register rd_reg one clock after the request.
- R11: The sequence compare-ge(A,B), move A to C, complement, move B to C leaves C[i] = max(A[i], B[i]) for i < vlen, with C unchanged above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Element load strobe (idle only) |
| ld_reg | input | log2(NREG) | Load register select |
| ld_idx | input | log2(NELEM) | Load element index |
| ld_data | input | EW | Load value |
| rd_reg | input | log2(NREG) | Read register select |
| rd_idx | input | log2(NELEM) | Read element index |
| rd_data | output | EW | Registered read value |
| start | input | 1 | Command strobe, taken when not busy |
| op | input | 3 | 0 cmp-ge, 1 cmp-zero, 2 mask complement, 3 add, 4 move |
| dense | input | 1 | 1 = dense issue, 0 = gated issue |
| vlen | input | log2(NELEM+1) | Vector length |
| dst | input | log2(NREG) | Destination register |
| src_a | input | log2(NREG) | First source register |
| src_b | input | log2(NREG) | Second source register |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| exec_count | output | log2(NELEM+1) | Elements issued by the last command |
| mask_out | output | NELEM | Current mask register |

## Verification
A corrupted pending-element set shows up as a done pulse at the wrong edge or a wrong exec_count at the end of the same command. Because the bench counts edges from acceptance to done, this is caught without waiting for data to be read. A wrong mask bit shows on mask_out as soon as the command completes. It is then confirmed when the next masked move or add writes or spares the wrong element, which the bench detects when it reads the whole destination register back right after that command. A wrong write-port select corrupts either a loaded element or an element outside the mask, and this is seen on the first readback of the affected register.

// File: rtl/mvx_pkg.sv
package mvx_pkg;

  typedef enum logic [2:0] {
    OP_CMPGE = 3'd0,
    OP_CMPZ  = 3'd1,
    OP_MNOT  = 3'd2,
    OP_ADD   = 3'd3,
    OP_MOVE  = 3'd4
  } mvx_op_e;

  function automatic logic op_writes_mask(input logic [2:0] o);
    return (o == OP_CMPGE) || (o == OP_CMPZ) || (o == OP_MNOT);
  endfunction

  function automatic logic op_writes_data(input logic [2:0] o);
    return (o == OP_ADD) || (o == OP_MOVE);
  endfunction

endpackage

// File: rtl/mvx_scan.sv
// Picks the lowest pending element and returns the set with it removed.
module mvx_scan #(
  parameter int NELEM = 8,
  parameter int IW    = $clog2(NELEM)
) (
  input  logic [NELEM-1:0] pend,
  output logic             hit,
  output logic [IW-1:0]    idx,
  output logic [NELEM-1:0] pend_next
);
  always_comb begin
    hit = |pend;
    idx = '0;
    for (int i = NELEM - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
    pend_next = pend & ~({{(NELEM-1){1'b0}}, hit} << idx);
  end
endmodule

// File: rtl/mvx_vrf.sv
// Vector register file: one write port, two combinational element reads
// for the datapath, one registered read for inspection.
module mvx_vrf #(
  parameter int EW    = 16,
  parameter int NELEM = 8,
  parameter int NREG  = 4,
  parameter int RW    = $clog2(NREG),
  parameter int IW    = $clog2(NELEM)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] wreg,
  input  logic [IW-1:0] widx,
  input  logic [EW-1:0] wdata,
  input  logic [RW-1:0] ra_reg,
  input  logic [IW-1:0] ra_idx,
  output logic [EW-1:0] ra_data,
  input  logic [RW-1:0] rb_reg,
  input  logic [IW-1:0] rb_idx,
  output logic [EW-1:0] rb_data,
  input  logic [RW-1:0] rq_reg,
  input  logic [IW-1:0] rq_idx,
  output logic [EW-1:0] rq_data
);
  localparam int DEPTH = NREG * NELEM;
  localparam int AW    = RW + IW;

  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[{wreg, widx}] <= wdata;
  end

  always_ff @(posedge clk) begin
    rq_data <= mem[{rq_reg, rq_idx}];
  end

  assign ra_data = mem[AW'({ra_reg, ra_idx})];
  assign rb_data = mem[AW'({rb_reg, rb_idx})];
endmodule

// File: rtl/mvx_mask.sv
module mvx_mask #(
  parameter int NELEM = 8,
  parameter int IW    = $clog2(NELEM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_en,
  input  logic [NELEM-1:0] keep,
  input  logic             upd_en,
  input  logic [IW-1:0]    upd_idx,
  input  logic             upd_bit,
  output logic [NELEM-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (clr_en) begin
      mask_q <= mask_q & keep;
    end else if (upd_en) begin
      mask_q[upd_idx] <= upd_bit;
    end
  end

  // R2: an element update changes at most one mask bit
  assert_single_bit_update_R2: assert property (@(posedge clk) disable iff (rst)
    upd_en && !clr_en |=> $countones(mask_q ^ $past(mask_q)) <= 1);
endmodule

// File: rtl/mvx_alu.sv
module mvx_alu
  import mvx_pkg::*;
#(
  parameter int EW = 16
) (
  input  logic [2:0]    op,
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  input  logic          mbit,
  output logic [EW-1:0] res,
  output logic          flag
);
  always_comb begin
    res  = a;
    flag = mbit;
    case (op)
      OP_CMPGE: flag = ($signed(a) >= $signed(b));
      OP_CMPZ:  flag = (a == '0);
      OP_MNOT:  flag = ~mbit;
      OP_ADD:   res  = a + b;
      OP_MOVE:  res  = a;
      default:  res  = a;
    endcase
  end
endmodule

// File: rtl/masked_vec_unit.sv
module masked_vec_unit
  import mvx_pkg::*;
#(
  parameter int EW    = 16,
  parameter int NELEM = 8,
  parameter int NREG  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ld_en,
  input  logic [$clog2(NREG)-1:0]    ld_reg,
  input  logic [$clog2(NELEM)-1:0]   ld_idx,
  input  logic [EW-1:0]              ld_data,
  input  logic [$clog2(NREG)-1:0]    rd_reg,
  input  logic [$clog2(NELEM)-1:0]   rd_idx,
  output logic [EW-1:0]              rd_data,
  input  logic                       start,
  input  logic [2:0]                 op,
  input  logic                       dense,
  input  logic [$clog2(NELEM+1)-1:0] vlen,
  input  logic [$clog2(NREG)-1:0]    dst,
  input  logic [$clog2(NREG)-1:0]    src_a,
  input  logic [$clog2(NREG)-1:0]    src_b,
  output logic                       busy,
  output logic                       done,
  output logic [$clog2(NELEM+1)-1:0] exec_count,
  output logic [NELEM-1:0]           mask_out
);
  localparam int IW = $clog2(NELEM);
  localparam int RW = $clog2(NREG);
  localparam int LW = $clog2(NELEM + 1);

  // command state
  logic             busy_q, done_q, dense_q;
  logic [2:0]       op_q;
  logic [RW-1:0]    dst_q, sa_q, sb_q;
  logic [LW-1:0]    cnt_q, vlen_q;
  logic [NELEM-1:0] pend_q, vm_q;

  logic [NELEM-1:0] start_vm, pend_init, pend_nx, mask_q;
  logic             hit, accept, exec, wen_exec, upd_en, flag;
  logic [IW-1:0]    idx;
  logic [EW-1:0]    a_el, b_el, res;

  always_comb begin
    for (int i = 0; i < NELEM; i++) start_vm[i] = (LW'(i) < vlen);
  end

  assign accept    = start && !busy_q;
  assign pend_init = (dense && op_writes_data(op)) ? (mask_q & start_vm) : start_vm;

  mvx_scan #(.NELEM(NELEM), .IW(IW)) u_scan (
    .pend(pend_q), .hit(hit), .idx(idx), .pend_next(pend_nx)
  );

  assign exec     = busy_q && hit;
  assign wen_exec = exec && op_writes_data(op_q) && mask_q[idx];
  assign upd_en   = exec && op_writes_mask(op_q);

  mvx_vrf #(.EW(EW), .NELEM(NELEM), .NREG(NREG), .RW(RW), .IW(IW)) u_vrf (
    .clk(clk),
    .we(busy_q ? wen_exec : ld_en),
    .wreg(busy_q ? dst_q : ld_reg),
    .widx(busy_q ? idx : ld_idx),
    .wdata(busy_q ? res : ld_data),
    .ra_reg(sa_q), .ra_idx(idx), .ra_data(a_el),
    .rb_reg(sb_q), .rb_idx(idx), .rb_data(b_el),
    .rq_reg(rd_reg), .rq_idx(rd_idx), .rq_data(rd_data)
  );

  mvx_alu #(.EW(EW)) u_alu (
    .op(op_q), .a(a_el), .b(b_el), .mbit(mask_q[idx]), .res(res), .flag(flag)
  );

  mvx_mask #(.NELEM(NELEM), .IW(IW)) u_mask (
    .clk(clk), .rst(rst),
    .clr_en(accept && op_writes_mask(op)), .keep(start_vm),
    .upd_en(upd_en), .upd_idx(idx), .upd_bit(flag),
    .mask_q(mask_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      dense_q <= 1'b0;
      op_q    <= '0;
      dst_q   <= '0;
      sa_q    <= '0;
      sb_q    <= '0;
      cnt_q   <= '0;
      vlen_q  <= '0;
      pend_q  <= '0;
      vm_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        dense_q <= dense;
        op_q    <= op;
        dst_q   <= dst;
        sa_q    <= src_a;
        sb_q    <= src_b;
        cnt_q   <= '0;
        vlen_q  <= vlen;
        vm_q    <= start_vm;
        pend_q  <= pend_init;
      end else if (busy_q) begin
        pend_q <= pend_nx;
        if (hit) cnt_q <= cnt_q + LW'(1);
        if (pend_nx == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign exec_count = cnt_q;
  assign mask_out   = mask_q;

  // R9: completion is a single-cycle pulse and never overlaps busy
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);
  // R5: issued elements never exceed the requested length
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
    done_q |-> cnt_q <= vlen_q);
  // R5: each issue slot retires exactly one pending element
  assert_scan_progress_R5: assert property (@(posedge clk) disable iff (rst)
    busy_q && hit |=> !busy_q || ($countones(pend_q) == $countones($past(pend_q)) - 1));
  // R6: dense issue sends only active elements down the pipe
  assert_dense_active_R6: assert property (@(posedge clk) disable iff (rst)
    busy_q && dense_q && op_writes_data(op_q) && hit |-> mask_q[idx]);
  // R3: after a mask command, no bit above the length survives
  assert_mask_tail_R3: assert property (@(posedge clk) disable iff (rst)
    done_q && op_writes_mask(op_q) |-> (mask_q & ~vm_q) == '0);
endmodule

// File: tb/masked_vec_unit_test.sv
`timescale 1ns/1ps
module masked_vec_unit_test;
  localparam int EW = 16, NELEM = 8, NREG = 4;
  localparam int RW = $clog2(NREG), IW = $clog2(NELEM), LW = $clog2(NELEM + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic ld_en = 1'b0, start = 1'b0, dense = 1'b0;
  logic [RW-1:0] ld_reg = '0, rd_reg = '0, dst = '0, src_a = '0, src_b = '0;
  logic [IW-1:0] ld_idx = '0, rd_idx = '0;
  logic [EW-1:0] ld_data = '0;
  logic [2:0] op = '0;
  logic [LW-1:0] vlen = '0;
  logic [EW-1:0] rd_data;
  logic busy, done;
  logic [LW-1:0] exec_count;
  logic [NELEM-1:0] mask_out;

  int n_tests = 0, n_fail = 0;
  logic [EW-1:0] model [NREG][NELEM];
  logic [NELEM-1:0] mmask;

  always #4 clk = ~clk;

  masked_vec_unit #(.EW(EW), .NELEM(NELEM), .NREG(NREG)) uut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_reg(ld_reg), .ld_idx(ld_idx), .ld_data(ld_data),
    .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data), .start(start), .op(op), .dense(dense),
    .vlen(vlen), .dst(dst), .src_a(src_a), .src_b(src_b), .busy(busy), .done(done),
    .exec_count(exec_count), .mask_out(mask_out)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] rnd_val();
    if ($urandom_range(0, 3) == 0) return '0;
    return EW'($urandom);
  endfunction

  task automatic load_elem(input int r, input int i, input logic [EW-1:0] v);
    ld_en = 1'b1; ld_reg = RW'(r); ld_idx = IW'(i); ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
    model[r][i] = v;
  endtask

  task automatic read_elem(input int r, input int i, output logic [EW-1:0] v);
    rd_reg = RW'(r); rd_idx = IW'(i);
    @(negedge clk);
    v = rd_data;
  endtask

  // compare a whole register against the model
  task automatic check_reg(input int r, input string req);
    logic [EW-1:0] v;
    int bad = -1;
    logic [EW-1:0] got = '0, want = '0;
    for (int i = 0; i < NELEM; i++) begin
      read_elem(r, i, v);
      if (v !== model[r][i] && bad < 0) begin bad = i; got = v; want = model[r][i]; end
    end
    chk(bad < 0, req, $sformatf("reg %0d element %0d", r, bad), int'(got), int'(want));
  endtask

  task automatic run_op(input int op_i, input bit dn, input int vl, input int d,
                        input int a, input int b, input string req);
    logic [EW-1:0] nv [NELEM];
    logic [NELEM-1:0] nm;
    int pop = 0, ecnt, slots, n = 0;
    nm = mmask;
    for (int i = 0; i < NELEM; i++) nv[i] = model[d][i];
    for (int i = 0; i < NELEM; i++) begin
      if (i < vl) begin
        if (mmask[i]) pop++;
        case (op_i)
          0: nm[i] = ($signed(model[a][i]) >= $signed(model[b][i]));
          1: nm[i] = (model[a][i] == '0);
          2: nm[i] = ~mmask[i];
          3: if (mmask[i]) nv[i] = model[a][i] + model[b][i];
          default: if (mmask[i]) nv[i] = model[a][i];
        endcase
      end else if (op_i <= 2) begin
        nm[i] = 1'b0;
      end
    end
    ecnt  = (op_i >= 3 && dn) ? pop : vl;
    slots = (ecnt == 0) ? 1 : ecnt;
    op = 3'(op_i); dense = dn; vlen = LW'(vl); dst = RW'(d); src_a = RW'(a); src_b = RW'(b);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 64) begin
      @(negedge clk);
      n++;
    end
    chk(n == slots, req, "slots to done (R9)", n, slots);
    chk(int'(exec_count) == ecnt, req, "exec_count", int'(exec_count), ecnt);
    @(negedge clk);
    chk(!done && !busy, "R9", "done one cycle", int'(done), 0);
    chk(mask_out == nm, req, "mask_out", int'(mask_out), int'(nm));
    mmask = nm;
    for (int i = 0; i < NELEM; i++) model[d][i] = nv[i];
    if (op_i >= 3) check_reg(d, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [EW-1:0] v;
    int s;
    s = int'($urandom(32'd2024));
    mmask = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1", "busy/done", int'({busy, done}), 0);
    chk(exec_count == '0, "R1", "exec_count", int'(exec_count), 0);
    chk(mask_out == '0, "R1", "mask_out", int'(mask_out), 0);

    // R10 load and read back every register
    for (int r = 0; r < NREG; r++)
      for (int i = 0; i < NELEM; i++) load_elem(r, i, rnd_val());
    for (int r = 0; r < NREG; r++) check_reg(r, "R10");
    read_elem(1, 3, v);
    chk(v == model[1][3], "R10", "single read", int'(v), int'(model[1][3]));

    // R11 element select: C = max(A,B), gated and dense
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < NELEM; i++) begin
        load_elem(0, i, EW'(i * 37 - 100));
        load_elem(1, i, EW'(50 - i * 13));
        load_elem(2, i, 16'hBEEF);
      end
      run_op(0, pass[0], (pass == 0) ? NELEM : 5, 0, 0, 1, "R2");
      run_op(4, pass[0], (pass == 0) ? NELEM : 5, 2, 0, 0, "R4");
      run_op(2, pass[0], (pass == 0) ? NELEM : 5, 0, 0, 0, "R3");
      run_op(4, pass[0], (pass == 0) ? NELEM : 5, 2, 1, 1, "R11");
      for (int i = 0; i < NELEM; i++) begin
        logic [EW-1:0] e;
        read_elem(2, i, v);
        if (i < ((pass == 0) ? NELEM : 5))
          e = ($signed(model[0][i]) >= $signed(model[1][i])) ? model[0][i] : model[1][i];
        else e = 16'hBEEF;
        chk(v == e, "R11", $sformatf("select element %0d", i), int'(v), int'(e));
      end
    end

    // R7 dense with empty mask: clear mask via compare-zero on nonzero data
    for (int i = 0; i < NELEM; i++) load_elem(3, i, EW'(i + 1));
    run_op(1, 1'b0, NELEM, 0, 3, 3, "R2");
    run_op(3, 1'b1, NELEM, 2, 0, 1, "R7");
    run_op(4, 1'b1, 0, 2, 0, 1, "R7");
    // R5 zero length gated still takes one slot
    run_op(3, 1'b0, 0, 2, 0, 1, "R5");
    // R8 mask ops ignore dense
    run_op(2, 1'b1, 6, 0, 0, 0, "R8");
    run_op(3, 1'b1, NELEM, 1, 1, 3, "R6");
    run_op(3, 1'b0, NELEM, 1, 1, 3, "R5");

    // constrained random mix
    for (int k = 0; k < 80; k++) begin
      int o, vl;
      if ($urandom_range(0, 4) == 0) begin
        int r = $urandom_range(0, NREG - 1);
        for (int i = 0; i < NELEM; i++) load_elem(r, i, rnd_val());
      end
      o  = $urandom_range(0, 4);
      vl = $urandom_range(0, NELEM);
      run_op(o, 1'($urandom_range(0, 1)), vl, $urandom_range(0, NREG - 1),
             $urandom_range(0, NREG - 1), $urandom_range(0, NREG - 1),
             (o == 2) ? "R3" : (o <= 1) ? "R2" : "R4");
    end
    for (int r = 0; r < NREG; r++) check_reg(r, "R4");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule